// File: doc/BRIEF.md
# Two-Rate Successive Approximation Controller

This block sequences a successive-approximation conversion of up to 14 bits. It drives a trial code into an external converter and reads back one comparator bit. That bit reports whether the trial value is at or below the analog input. Bits are decided from the most significant one downward. The upper eight decisions each get a longer settling interval than the lower six, because the converter output moves further and needs more time to settle while the large bits are tried. Every interval is counted in enabled cycles of a clock-enable input, so the whole sequence can run at a fraction of the system clock.

A hold/run input selects between two behaviours. While the input is low the controller converts back to back. While it is high the controller stops after the conversion in progress, and a low pulse on the input starts one more conversion. A stop-step input ends a conversion early, after fewer bits, and the bits it did not resolve read as zero. A bipolar input selects two's-complement coding: the sense of the most significant trial bit is inverted, so a signed input range maps onto a signed code. Both settings are captured when a conversion starts. The busy output is high while a conversion runs, and its falling edge marks the cycle in which a new result appears.

Top module: `two_rate_sar_ctrl`

## Requirements
- R1: The conversion decides bits 13 down to 0 in that order. In the first cycle with busy high, trial_code has only bit 13 set (0x2000) in unipolar mode, and it is 0x0000 in bipolar mode.
- R2: Each of bits 13..6 holds its trial for SLOW_STEP enabled cycles (default 4), and each of bits 5..0 holds its trial for FAST_STEP enabled cycles (default 1). A full conversion keeps busy high for 38 enabled cycles.
- R3: A trial bit stays 1 when cmp_le is 1 (trial at or below the input) on the last enabled cycle of its interval, and is cleared otherwise. A full unipolar conversion of an input value V in 0..16383 gives result = V.
- R4: stop_step (4 bits) is captured at start. The number of bits decided is stop_step-1, clamped to the range 1..14, so 15 gives a full conversion and 0 or 1 gives one bit. The undecided low bits of the result read 0, and busy is shorter by the skipped intervals.
- R5: In idle, any enabled cycle with hold_run low starts a conversion. With hold_run held low, conversions repeat, with busy low for exactly one enabled cycle between them.
- R6: In idle, an enabled cycle with hold_run high leaves the block idle with result unchanged. A one-cycle low pulse on hold_run starts exactly one conversion.
- R7: result changes only on the clock edge at which busy falls.
- R8: bipolar (1 = two's complement) is captured at start. In bipolar mode trial_code and result are two's-complement codes. For a signed input V in -8192..8191 the full result is V, and a short conversion gives V rounded down to the decided resolution.
- R9: A clock edge with step_en low changes none of busy, trial_code or result.
- R10: After reset, busy is 0, result is 0 and trial_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Clock enable; all timing counts enabled cycles |
| hold_run | input | 1 | Low: run continuously; high: stop after current conversion |
| cmp_le | input | 1 | Comparator: 1 when trial value is at or below the input |
| bipolar | input | 1 | 1 selects two's-complement coding |
| stop_step | input | 4 | Short-cycle step; bits decided = clamp(stop_step-1, 1, 14) |
| trial_code | output | 14 | Code driven to the converter |
| result | output | 14 | Last completed conversion |
| busy | output | 1 | High while a conversion runs |

## Verification
Busy rises one cycle after the enabled edge that samples hold_run low, and the first trial code is visible in that same cycle. The result is registered on the edge at which busy falls, which comes 38 enabled cycles after the start edge for a full conversion and fewer for a short one. The scoreboard monitor samples on the falling clock edge. It checks the first trial when busy rises, and it compares the result and the enabled-cycle length of the conversion in the cycle where busy is first seen low, so clock-enable stalls do not shift the expected timing. Idle gaps and stop behaviour are measured the same way, in enabled cycles between busy transitions.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } run_state_e;

    typedef struct packed {
        logic advance;
        logic finish;
    } walk_evt_t;

    // Index of the lowest bit decided for a given short-cycle setting.
    function automatic int last_index(int stop_val, int nbits);
        int nb;
        nb = stop_val - 1;
        if (nb < 1) nb = 1;
        if (nb > nbits) nb = nbits;
        return nbits - nb;
    endfunction

    // Interval length, in enabled cycles, for the trial of bit idx.
    function automatic int step_len(int idx, int nbits, int slow_bits,
                                    int slow_len, int fast_len);
        return (idx >= nbits - slow_bits) ? slow_len : fast_len;
    endfunction

endpackage

// File: rtl/sar_run_fsm.sv
module sar_run_fsm
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic hold_run,
    input  logic finish,
    output logic start,
    output logic busy
);

    run_state_e state;

    assign start = step_en && (state == ST_IDLE) && !hold_run;
    assign busy  = (state == ST_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else if (start) begin
            state <= ST_CONV;
        end else if (finish) begin
            state <= ST_IDLE;
        end
    end

endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS     = 14,
    parameter int SLOW_BITS = 8,
    parameter int SLOW_STEP = 4,
    parameter int FAST_STEP = 1,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    output logic             expire
);

    localparam int MAX_STEP = (SLOW_STEP > FAST_STEP) ? SLOW_STEP : FAST_STEP;
    localparam int CNT_W    = $clog2(MAX_STEP + 1);

    generate
        if (MAX_STEP == 1) begin : g_no_wait
            assign expire = 1'b1;
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (step_en) begin
                    if (load) begin
                        cnt <= CNT_W'(step_len(int'(load_idx), NBITS, SLOW_BITS,
                                               SLOW_STEP, FAST_STEP) - 1);
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end

            assign expire = (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/sar_bit_walker.sv
module sar_bit_walker
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS  = 14,
    parameter int STOP_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              decide,
    input  logic              cmp_le,
    input  logic              bipolar,
    input  logic [STOP_W-1:0] stop_step,
    output walk_evt_t         evt,
    output logic [IDX_W-1:0]  next_idx,
    output logic [NBITS-1:0]  trial_code,
    output logic [NBITS-1:0]  result,
    output logic              mode
);

    // acc holds the trial in offset-binary form; the MSB is flipped on output
    // in two's-complement mode, which inverts the sense of the first trial.
    logic [NBITS-1:0] acc;
    logic [NBITS-1:0] acc_dec;
    logic [NBITS-1:0] bit_mask;
    logic [NBITS-1:0] below_mask;
    logic [NBITS-1:0] flip;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;
    logic             at_last;

    assign at_last     = (idx == last);
    assign evt.finish  = decide && at_last;
    assign evt.advance = decide && !at_last;
    assign next_idx    = start ? IDX_W'(NBITS - 1) : (idx - IDX_W'(1));

    always_comb begin
        bit_mask   = NBITS'(1) << idx;
        below_mask = bit_mask >> 1;
        acc_dec    = cmp_le ? (acc | bit_mask) : (acc & ~bit_mask);
        flip       = {mode, {(NBITS-1){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            idx    <= '0;
            last   <= '0;
            mode   <= 1'b0;
            result <= '0;
        end else if (start) begin
            mode <= bipolar;
            last <= IDX_W'(last_index(int'(stop_step), NBITS));
            idx  <= IDX_W'(NBITS - 1);
            acc  <= {1'b1, {(NBITS-1){1'b0}}};
        end else if (decide) begin
            if (at_last) begin
                acc    <= acc_dec;
                result <= acc_dec ^ flip;
            end else begin
                acc <= acc_dec | below_mask;
                idx <= idx - IDX_W'(1);
            end
        end
    end

    assign trial_code = acc ^ flip;

endmodule

// File: rtl/two_rate_sar_ctrl.sv
module two_rate_sar_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS     = 14,
    parameter int SLOW_BITS = 8,
    parameter int SLOW_STEP = 4,
    parameter int FAST_STEP = 1,
    parameter int IDX_W     = $clog2(NBITS),
    parameter int STOP_W    = $clog2(NBITS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              hold_run,
    input  logic              cmp_le,
    input  logic              bipolar,
    input  logic [STOP_W-1:0] stop_step,
    output logic [NBITS-1:0]  trial_code,
    output logic [NBITS-1:0]  result,
    output logic              busy
);

    walk_evt_t        evt;
    logic             start;
    logic             expire;
    logic             decide;
    logic             bip_mode;
    logic [IDX_W-1:0] next_idx;

    assign decide = step_en && busy && expire;

    sar_run_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .hold_run (hold_run),
        .finish   (evt.finish),
        .start    (start),
        .busy     (busy)
    );

    sar_step_timer #(
        .NBITS     (NBITS),
        .SLOW_BITS (SLOW_BITS),
        .SLOW_STEP (SLOW_STEP),
        .FAST_STEP (FAST_STEP),
        .IDX_W     (IDX_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .load     (start || evt.advance),
        .load_idx (next_idx),
        .expire   (expire)
    );

    sar_bit_walker #(
        .NBITS  (NBITS),
        .STOP_W (STOP_W),
        .IDX_W  (IDX_W)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .decide     (decide),
        .cmp_le     (cmp_le),
        .bipolar    (bipolar),
        .stop_step  (stop_step),
        .evt        (evt),
        .next_idx   (next_idx),
        .trial_code (trial_code),
        .result     (result),
        .mode       (bip_mode)
    );

endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
    parameter int NBITS = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             hold_run,
    input logic             busy,
    input logic             mode,
    input logic [NBITS-1:0] trial_code,
    input logic [NBITS-1:0] result
);

    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $fell(busy)); // R7

    AST_FROZEN_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !$past(step_en) |-> ($stable(trial_code) && $stable(busy) && $stable(result))); // R9

    AST_MSB_TRIAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((trial_code[NBITS-2:0] == '0) && (trial_code[NBITS-1] == !mode))); // R1 R8

    AST_HOLD_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (step_en && !busy && hold_run) |=> !busy); // R6

    AST_LOW_STARTS: assert property (@(posedge clk) disable iff (rst)
        (step_en && !busy && !hold_run) |=> busy); // R5

endmodule

bind two_rate_sar_ctrl sar_ctrl_checker #(.NBITS(NBITS)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .hold_run   (hold_run),
    .busy       (busy),
    .mode       (bip_mode),
    .trial_code (trial_code),
    .result     (result)
);

// File: tb/two_rate_sar_ctrl_bench.sv
module two_rate_sar_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b1;
    logic        hold_run = 1'b1;
    logic        cmp_le;
    logic        bipolar = 1'b0;
    logic [3:0]  stop_step = 4'd15;
    logic [13:0] trial_code;
    logic [13:0] result;
    logic        busy;

    int vin = 0;
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int rises = 0;
    int run_len = 0;
    int idle_len = 0;
    bit prev_busy = 1'b0;
    bit gap_chk = 1'b0;

    typedef struct {
        logic [13:0] res;
        logic [13:0] first;
        int          len;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    two_rate_sar_ctrl u_two_rate_sar_ctrl (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .hold_run   (hold_run),
        .cmp_le     (cmp_le),
        .bipolar    (bipolar),
        .stop_step  (stop_step),
        .trial_code (trial_code),
        .result     (result),
        .busy       (busy)
    );

    // Converter and comparator model.
    always_comb begin
        int tv;
        tv = bipolar ? int'($signed(trial_code)) : int'(trial_code);
        cmp_le = (tv <= vin);
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t make_exp(int v, bit bip, int stop, string tag);
        exp_t e;
        int nb;
        logic [13:0] m;
        nb = stop - 1;
        if (nb < 1) nb = 1;
        if (nb > 14) nb = 14;
        m = 14'(32'h3fff << (14 - nb));
        e.res = 14'(v) & m;
        e.first = bip ? 14'h0000 : 14'h2000;
        e.len = 0;
        for (int k = 0; k < nb; k++) e.len += (k < 8) ? 4 : 1;
        e.tag = tag;
        return e;
    endfunction

    // Monitor: compares as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !prev_busy) begin
                rises++;
                if (q.size() > 0)
                    chk(trial_code == q[0].first, {q[0].tag, " R1 first trial"},
                        int'(trial_code), int'(q[0].first));
                if (gap_chk)
                    chk(idle_len == 1, "R5 idle gap", idle_len, 1);
                run_len = 0;
            end
            if (!busy && prev_busy) begin
                done_cnt++;
                idle_len = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R7 unexpected completion", int'(result), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(result == e.res, {e.tag, " R3 result"}, int'(result), int'(e.res));
                    chk(run_len == e.len, {e.tag, " R2 length"}, run_len, e.len);
                end
            end
            if (busy && step_en) run_len++;
            if (!busy && step_en) idle_len++;
            prev_busy = busy;
        end
    end

    task automatic convert(int v, bit bip, int stop, string tag);
        int target;
        @(posedge clk); #1;
        vin = v;
        bipolar = bip;
        stop_step = 4'(stop);
        q.push_back(make_exp(v, bip, stop, tag));
        target = done_cnt + 1;
        hold_run = 1'b0;
        @(posedge clk); #1;
        hold_run = 1'b1;
        wait (done_cnt >= target);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base_done;
        int base_rises;
        logic [13:0] held_res;
        logic [13:0] held_trial;
        bit stable_ok;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        chk(result == 14'h0, "R10 reset result", int'(result), 0);
        chk(trial_code == 14'h0, "R10 reset trial", int'(trial_code), 0);

        // Full unipolar conversions, pulse restart each time (R6).
        convert(12345, 1'b0, 15, "R3");
        convert(0, 1'b0, 15, "R3 zero");
        convert(16383, 1'b0, 15, "R3 full");
        convert(8192, 1'b0, 15, "R1 mid");
        convert(8191, 1'b0, 15, "R1 below mid");

        // Short cycle.
        convert(12345, 1'b0, 9, "R4 eight bits");
        convert(16383, 1'b0, 1, "R4 one bit");
        convert(16383, 1'b0, 0, "R4 zero clamps");
        convert(5000, 1'b0, 12, "R4 eleven bits");

        // Two's complement.
        convert(-1, 1'b1, 15, "R8 minus one");
        convert(-8192, 1'b1, 15, "R8 most negative");
        convert(8191, 1'b1, 15, "R8 most positive");
        convert(-1234, 1'b1, 9, "R8 short");

        // Stop: idle with hold high leaves everything alone.
        base_rises = rises;
        held_res = result;
        repeat (40) @(negedge clk);
        chk(rises == base_rises, "R6 no start while held", rises, base_rises);
        chk(result == held_res, "R6 result held", int'(result), int'(held_res));

        // Clock-enable stall mid conversion.
        @(posedge clk); #1;
        vin = 3333; bipolar = 1'b0; stop_step = 4'd15;
        q.push_back(make_exp(3333, 1'b0, 15, "R9 stalled"));
        base_done = done_cnt;
        hold_run = 1'b0;
        @(posedge clk); #1;
        hold_run = 1'b1;
        repeat (6) @(posedge clk);
        #1 step_en = 1'b0;
        @(negedge clk);
        held_trial = trial_code;
        held_res = result;
        stable_ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (trial_code != held_trial || result != held_res || !busy) stable_ok = 1'b0;
        end
        chk(stable_ok, "R9 frozen while disabled", int'(trial_code), int'(held_trial));
        @(posedge clk); #1 step_en = 1'b1;
        wait (done_cnt >= base_done + 1);

        // Free run, then stop after the third conversion.
        @(posedge clk); #1;
        vin = 9000; bipolar = 1'b0; stop_step = 4'd15;
        for (int i = 0; i < 3; i++) q.push_back(make_exp(9000, 1'b0, 15, "R5 free run"));
        base_done = done_cnt;
        base_rises = rises;
        hold_run = 1'b0;
        wait (done_cnt >= base_done + 1);
        gap_chk = 1'b1;
        wait (done_cnt >= base_done + 2);
        @(posedge clk); #1 hold_run = 1'b1;
        wait (done_cnt >= base_done + 3);
        gap_chk = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R6 stopped after run", int'(busy), 0);
        chk(rises == base_rises + 3, "R5 conversion count", rises - base_rises, 3);
        chk(q.size() == 0, "R7 all results seen", q.size(), 0);

        finish_run();
    end

endmodule